// File: doc/BRIEF.md
# NMI Flag Collector with Service Watchdog

This block gathers six hardware fault sources into sticky per-source flag bits and raises a non-maskable interrupt to a CPU. The sources are an external pin event, a clock failure, an interrupt-expander error, a second-core NMI watchdog reset, an inter-core bus error and a built-in self-test error. Whenever any source flag is set, a summary NMI flag latches. When that summary flag rises, the block emits a single-cycle interrupt pulse.

Once an NMI is pending, a service watchdog counts clock cycles against a programmable period. If software has not cleared every flag before the count reaches the period, the block issues a one-cycle device reset request. Software uses a small register port to read the flags, clear them, force them for testing, enable the gated source, and program the period. The counter value can also be read back.

Top module: `nmi_supervisor`

## Requirements
- R1: After reset, the flag, count and config registers read 0, the period register reads 0xFFFF, and `nmi_pulse` and `rst_req` are low.
- R2: Source `src_evt[i]` (i = 0..5) sets a sticky flag at bit i+1 of the flag register, which is at address 0. Bit 0 of that register is the summary NMI flag. A set flag stays set until it is cleared.
- R3: Source 4 (the inter-core bus error, flag bit 5) has no effect until bit 9 of the config register (address 3) is written with 1. After that, writes of 0 leave bit 9 at 1, and only reset clears it.
- R4: Writing 1 to bit i+1 of the force register (address 2) sets source flag i and raises the NMI exactly as an event does. Force works whether or not the source is enabled.
- R5: Writing 1 to a bit of the clear register (address 1) clears the flag at the same bit position. Bit 0 clears the summary flag.
- R6: The summary flag is set in the same cycle as any source flag. `nmi_pulse` is high for exactly one cycle, in the cycle where the summary flag goes from 0 to 1. A further event while the summary flag is already set gives no pulse.
- R7: If a set event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R8: While any flag is set, the counter (address 5) advances by one per clock, starting from 0.
- R9: After the count reaches the period (address 4), `rst_req` is high for exactly one cycle. The counter then holds its value.
- R10: The counter returns to 0 only after all source flags and the summary flag are clear. A partial clear leaves it unchanged.
- R11: Writes to the flag and count addresses are ignored. The clear and force addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low subsystem reset |
| src_evt | input | 6 | Fault source event pulses, index 0..5 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` (combinational) |
| nmi_pulse | output | 1 | One-cycle NMI request to the CPU |
| rst_req | output | 1 | One-cycle device reset request |

## Verification
Two things can fall in the same cycle: a hardware event that sets a flag, and a software clear write aimed at that same flag. The stimulus table provokes this by driving a source pulse together with a clear write whose mask covers that source's bit. The check then reads the flag register and expects the bit to still be set, while bits cleared in the same write are gone. The watchdog sequence also issues a partial clear while the counter is held at the period, and checks that the count does not return to zero.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
   localparam int unsigned NMI_SRC_CNT = 6;
   localparam int unsigned NMI_ADDR_W  = 3;

   typedef enum logic [NMI_ADDR_W-1:0] {
      REG_FLAGS  = 3'd0,
      REG_CLEAR  = 3'd1,
      REG_FORCE  = 3'd2,
      REG_CONFIG = 3'd3,
      REG_PERIOD = 3'd4,
      REG_COUNT  = 3'd5
   } nmi_reg_e;
endpackage

// File: rtl/nmi_flag_bank.sv
module nmi_flag_bank #(
   parameter int unsigned NUM_SRC   = 6,
   parameter int unsigned GATED_IDX = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [NUM_SRC-1:0] frc,
   input  logic [NUM_SRC-1:0] clr_src,
   input  logic               clr_sum,
   input  logic               gate_en,
   output logic [NUM_SRC-1:0] src_flags,
   output logic               sum_flag,
   output logic               nmi_pulse
);
   logic [NUM_SRC-1:0] src_en;
   logic [NUM_SRC-1:0] set_v;
   logic               sum_d;

   if (GATED_IDX >= NUM_SRC) begin : g_bad_gate
      $error("GATED_IDX must index an existing source");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == GATED_IDX) begin : g_gated
         assign src_en[i] = gate_en;
      end else begin : g_open
         assign src_en[i] = 1'b1;
      end

      assign set_v[i] = (evt[i] & src_en[i]) | frc[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) src_flags[i] <= 1'b0;
         else        src_flags[i] <= set_v[i] | (src_flags[i] & ~clr_src[i]);
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_v[i] |=> src_flags[i]); // R7
   end

   assign sum_d = (|set_v) | (sum_flag & ~clr_sum);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_flag  <= 1'b0;
         nmi_pulse <= 1'b0;
      end else begin
         sum_flag  <= sum_d;
         nmi_pulse <= sum_d & ~sum_flag;
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pulse |=> !nmi_pulse); // R6
   AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pulse |-> (sum_flag && !$past(sum_flag))); // R6
   AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en && !frc[GATED_IDX] && !src_flags[GATED_IDX]) |=> !src_flags[GATED_IDX]); // R3
endmodule

// File: rtl/nmi_wdog.sv
module nmi_wdog #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             rst_req
);
   logic hit;
   logic fired;

   if (CNT_W < 2) begin : g_bad_width
      $error("CNT_W must be at least 2");
   end

   assign hit = (cnt >= period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         fired   <= 1'b0;
         rst_req <= 1'b0;
      end else if (!active) begin
         cnt     <= '0;
         fired   <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         if (!hit) cnt <= cnt + 1'b1;
         rst_req <= hit & ~fired;
         if (hit) fired <= 1'b1;
      end
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0)); // R10
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt != '0) |=> (cnt != '0)); // R8
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R9
   AST_RST_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt >= period)); // R9
endmodule

// File: rtl/nmi_regfile.sv
module nmi_regfile
   import nmi_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 6,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned CFG_EN_BIT = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [NMI_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [NUM_SRC-1:0]    src_flags,
   input  logic                  sum_flag,
   input  logic [CNT_W-1:0]      cnt,
   output logic [NUM_SRC-1:0]    clr_src,
   output logic                  clr_sum,
   output logic [NUM_SRC-1:0]    frc,
   output logic                  gate_en,
   output logic [CNT_W-1:0]      period,
   output logic [DATA_W-1:0]     rdata
);
   localparam int unsigned FLAG_W = NUM_SRC + 1;

   logic wr_clear, wr_force, wr_cfg, wr_period;

   if (DATA_W < FLAG_W || DATA_W <= CFG_EN_BIT || CNT_W > DATA_W) begin : g_bad_map
      $error("register fields do not fit in DATA_W");
   end

   assign wr_clear  = wr_en && (addr == REG_CLEAR);
   assign wr_force  = wr_en && (addr == REG_FORCE);
   assign wr_cfg    = wr_en && (addr == REG_CONFIG);
   assign wr_period = wr_en && (addr == REG_PERIOD);

   assign clr_sum = wr_clear & wdata[0];
   assign clr_src = wr_clear ? wdata[NUM_SRC:1] : '0;
   assign frc     = wr_force ? wdata[NUM_SRC:1] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_en <= 1'b0;
         period  <= '1;
      end else begin
         if (wr_cfg)    gate_en <= gate_en | wdata[CFG_EN_BIT];
         if (wr_period) period  <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         REG_FLAGS:  rdata[FLAG_W-1:0] = {src_flags, sum_flag};
         REG_CONFIG: rdata[CFG_EN_BIT] = gate_en;
         REG_PERIOD: rdata[CNT_W-1:0]  = period;
         REG_COUNT:  rdata[CNT_W-1:0]  = cnt;
         default:    rdata = '0;
      endcase
   end

   AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en |=> gate_en); // R3
endmodule

// File: rtl/nmi_supervisor.sv
module nmi_supervisor
   import nmi_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned CFG_EN_BIT = 9,
   parameter int unsigned GATED_IDX  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NMI_SRC_CNT-1:0] src_evt,
   input  logic                   wr_en,
   input  logic [NMI_ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   output logic                   nmi_pulse,
   output logic                   rst_req
);
   localparam int unsigned NSRC = NMI_SRC_CNT;

   logic [NSRC-1:0]  src_flags, clr_src, frc;
   logic             sum_flag, clr_sum, gate_en, active;
   logic [CNT_W-1:0] period, cnt;

   nmi_regfile #(
      .NUM_SRC(NSRC), .DATA_W(DATA_W), .CNT_W(CNT_W), .CFG_EN_BIT(CFG_EN_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .src_flags(src_flags), .sum_flag(sum_flag), .cnt(cnt),
      .clr_src(clr_src), .clr_sum(clr_sum), .frc(frc), .gate_en(gate_en),
      .period(period), .rdata(rdata)
   );

   nmi_flag_bank #(.NUM_SRC(NSRC), .GATED_IDX(GATED_IDX)) u_flags (
      .clk(clk), .rst_n(rst_n), .evt(src_evt), .frc(frc), .clr_src(clr_src),
      .clr_sum(clr_sum), .gate_en(gate_en), .src_flags(src_flags),
      .sum_flag(sum_flag), .nmi_pulse(nmi_pulse)
   );

   assign active = sum_flag | (|src_flags);

   nmi_wdog #(.CNT_W(CNT_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .active(active), .period(period),
      .cnt(cnt), .rst_req(rst_req)
   );

   AST_SUM_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(src_flags) == '0 && src_flags != '0) |-> sum_flag); // R6
endmodule

// File: tb/sim_nmi_supervisor.sv
module sim_nmi_supervisor;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  src_evt = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        nmi_pulse, rst_req;

   int checks = 0;
   int errors = 0;

   // {event mask[5:0], clear mask[6:0], expected flag register[6:0]}
   localparam logic [19:0] VEC [0:8] = '{
      20'h04003, 20'h08007, 20'h40007, 20'h00105, 20'h1040D,
      20'h00680, 20'h80041, 20'h000C0, 20'h02000
   };

   always #(CLK_PERIOD/2) clk = ~clk;

   nmi_supervisor u0 (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .nmi_pulse(nmi_pulse), .rst_req(rst_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk); #1;
   endtask

   task automatic step(input logic [5:0] evt, input logic [6:0] clr);
      @(negedge clk);
      src_evt = evt;
      wr_en   = (clr != 0);
      addr    = 3'd1;
      wdata   = {9'd0, clr};
      @(posedge clk); @(negedge clk);
      src_evt = '0; wr_en = 1'b0; #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; #1;
   endtask

   function automatic logic [15:0] rd(input logic [2:0] a);
      addr = a;
      return 16'hxxxx;
   endfunction

   task automatic rdchk(input string req, input logic [2:0] a, input logic [15:0] exp);
      addr = a; #1;
      check(req, {16'd0, rdata}, {16'd0, exp});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #1;

      // R1 reset state
      rdchk("R1 flags", 3'd0, 16'h0000);
      rdchk("R1 count", 3'd5, 16'h0000);
      rdchk("R1 config", 3'd3, 16'h0000);
      rdchk("R1 period", 3'd4, 16'hFFFF);
      check("R1 nmi_pulse", {31'd0, nmi_pulse}, 0);
      check("R1 rst_req", {31'd0, rst_req}, 0);

      // R11 read-only and write-only registers
      wr(3'd0, 16'hFFFF);
      rdchk("R11 flag write ignored", 3'd0, 16'h0000);
      wr(3'd5, 16'h1234);
      rdchk("R11 count write ignored", 3'd5, 16'h0000);
      rdchk("R11 clear reads zero", 3'd1, 16'h0000);
      rdchk("R11 force reads zero", 3'd2, 16'h0000);

      // R2 R3 R5 R7 table walk
      for (int k = 0; k < 9; k++) begin
         step(VEC[k][19:14], VEC[k][13:7]);
         rdchk($sformatf("R2 R5 R7 vector %0d", k), 3'd0, {9'd0, VEC[k][6:0]});
      end
      cyc();
      rdchk("R10 idle count", 3'd5, 16'h0000);

      // R3 gated source enable is write-once
      wr(3'd3, 16'h0200);
      rdchk("R3 enable set", 3'd3, 16'h0200);
      step(6'h10, 7'h00);
      rdchk("R3 bus error flag", 3'd0, 16'h0021);
      wr(3'd3, 16'h0000);
      rdchk("R3 enable sticky", 3'd3, 16'h0200);
      wr(3'd1, 16'h007F);
      cyc();

      // R4 R6 force and pulse
      wr(3'd2, 16'h0004);
      check("R4 R6 pulse on force", {31'd0, nmi_pulse}, 1);
      rdchk("R4 forced flag", 3'd0, 16'h0005);
      cyc();
      check("R6 pulse one cycle", {31'd0, nmi_pulse}, 0);
      step(6'h01, 7'h00);
      check("R6 no pulse while pending", {31'd0, nmi_pulse}, 0);
      rdchk("R2 second flag", 3'd0, 16'h0007);
      wr(3'd1, 16'h007F);
      cyc();
      rdchk("R10 cleared count", 3'd5, 16'h0000);

      // R8 R9 R10 watchdog
      wr(3'd4, 16'd5);
      rdchk("R9 period readback", 3'd4, 16'd5);
      step(6'h04, 7'h00);
      rdchk("R8 count start", 3'd5, 16'd0);
      repeat (5) cyc();
      rdchk("R8 count at period", 3'd5, 16'd5);
      check("R9 no early reset", {31'd0, rst_req}, 0);
      cyc();
      check("R9 reset request", {31'd0, rst_req}, 1);
      cyc();
      check("R9 reset one cycle", {31'd0, rst_req}, 0);
      rdchk("R9 count holds", 3'd5, 16'd5);
      wr(3'd1, 16'h0001);
      rdchk("R5 summary cleared", 3'd0, 16'h0008);
      cyc();
      rdchk("R10 partial clear keeps count", 3'd5, 16'd5);
      wr(3'd1, 16'h0008);
      cyc();
      rdchk("R10 full clear zeroes count", 3'd5, 16'd0);
      check("R9 no repeat reset", {31'd0, rst_req}, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule